// File: doc/BRIEF.md
# TDM Frame Serializer

This block turns a stream of parallel bytes into one time-division-multiplexed serial line. A free-running position counter divides every frame into a fixed number of timeslots, each a fixed number of bit periods long (32 slots of 8 bits by default, so 256 bit periods per frame). Once per timeslot a byte is captured from the parallel bus into a shift register, and the shift register then sends one bit per clock, least-significant bit first.

Alongside the serial data the block drives a frame marker that is high for a single bit period, an active-low capture strobe that tells the upstream source when its byte is taken, and the number of the timeslot whose byte will be captured next. The upstream source uses that slot number to place the right channel's byte on the bus in time. The parallel bus is only looked at on the capture edge. Between those edges its value may change freely.

Top module: `tdm_serializer`

## Requirements
- R1: The position counter wraps every NUM_SLOTS*BITS_PER_SLOT clocks (256 by default), so the frame marker repeats with exactly that period.
- R2: `sync_o` is high for exactly one bit period per frame, during the final counter state (255 by default), which is the last bit of the last timeslot.
- R3: `load_n_o` is low (active) for one clock in every BITS_PER_SLOT clocks, during the last bit period (bit index 7 by default) of each timeslot, and high otherwise.
- R4: `slot_o` equals (current timeslot + 1) mod NUM_SLOTS. This is the slot whose byte is captured at the end of the current slot. It reads 0 during the last slot of a frame.
- R5: The byte on `pdata_i` is captured on the clock edge that ends a cycle with `load_n_o` low, and it is transmitted during the whole of the following timeslot.
- R6: Bits leave least-significant first: in bit period k of a timeslot (k = 0 to 7), `sdata_o` carries bit k of the captured byte.
- R7: `pdata_i` has no effect on `sdata_o` at any clock edge other than the capture edge.
- R8: A synchronous active-high `rst` puts the counter in state 0 and clears the shift register. While reset is held and in the first clock after its release, `sync_o`=0, `load_n_o`=1, `slot_o`=1 and `sdata_o`=0. The first timeslot after reset sends zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pdata_i | input | BITS_PER_SLOT | Parallel byte, sampled on the capture edge only |
| sdata_o | output | 1 | Serial data, LSB first |
| sync_o | output | 1 | One-bit-wide frame marker in the final counter state |
| slot_o | output | log2(NUM_SLOTS) | Number of the slot whose byte is captured next |
| load_n_o | output | 1 | Active-low capture strobe in the last bit of each slot |

## Verification
All four outputs are flops, so each one is valid through the whole clock period that follows the edge that set it. The bench keeps its own position count from the release of reset and compares every output at the falling edge of every cycle.

A byte driven while `load_n_o` is low is captured on the next rising edge. Its bit k is therefore due k+1 cycles after that strobe cycle. The bench records the byte at that edge and expects its bits only from the following cycle on.

Reset is checked one edge after it is asserted, and again in the first cycle after release.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  // Frame-position strobes derived one cycle early and registered.
  typedef struct packed {
    logic frame_end;  // final counter state of the frame
    logic capture;    // last bit of a timeslot
  } tdm_strobe_t;

endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
  import tdm_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SLOTS     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  output tdm_strobe_t                   strobe_q,
  output logic [$clog2(NUM_SLOTS)-1:0]  slot_ahead_q
);
  localparam int BIT_W  = $clog2(BITS_PER_SLOT);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int CNT_W  = BIT_W + SLOT_W;
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(BITS_PER_SLOT - 1);
  localparam logic [CNT_W-1:0] LAST_POS  = {CNT_W{1'b1}};

  logic [CNT_W-1:0]  pos_q;
  logic [CNT_W-1:0]  pos_nxt;
  logic [BIT_W-1:0]  bit_nxt;
  logic [SLOT_W-1:0] slot_nxt;
  logic [SLOT_W-1:0] slot_ahead_nxt;
  tdm_strobe_t       strobe_nxt;

  always_comb begin
    pos_nxt              = pos_q + CNT_W'(1);
    bit_nxt              = pos_nxt[BIT_W-1:0];
    slot_nxt             = pos_nxt[CNT_W-1:BIT_W];
    slot_ahead_nxt       = slot_nxt + SLOT_W'(1);
    strobe_nxt.frame_end = (pos_nxt == LAST_POS);
    strobe_nxt.capture   = (bit_nxt == LAST_BIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q        <= '0;
      strobe_q     <= '0;
      slot_ahead_q <= SLOT_W'(1);
    end else begin
      pos_q        <= pos_nxt;
      strobe_q     <= strobe_nxt;
      slot_ahead_q <= slot_ahead_nxt;
    end
  end
endmodule

// File: rtl/tdm_piso.sv
module tdm_piso #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] pdata,
  output logic             sdata
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_nxt;

  // Stage 0 drives the line, so bit 0 leaves first.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    if (i == WIDTH - 1) begin : g_top
      assign stage_nxt[i] = load ? pdata[i] : 1'b0;
    end else begin : g_mid
      assign stage_nxt[i] = load ? pdata[i] : stage_q[i+1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= stage_nxt;
  end

  assign sdata = stage_q[0];
endmodule

// File: rtl/tdm_serializer.sv
module tdm_serializer
  import tdm_pkg::*;
#(
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SLOTS     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BITS_PER_SLOT-1:0]      pdata_i,
  output logic                          sdata_o,
  output logic                          sync_o,
  output logic [$clog2(NUM_SLOTS)-1:0]  slot_o,
  output logic                          load_n_o
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  tdm_strobe_t       strobe;
  logic [SLOT_W-1:0] slot_ahead;

  tdm_frame_counter #(
    .BITS_PER_SLOT(BITS_PER_SLOT),
    .NUM_SLOTS    (NUM_SLOTS)
  ) u_counter (
    .clk         (clk),
    .rst         (rst),
    .strobe_q    (strobe),
    .slot_ahead_q(slot_ahead)
  );

  tdm_piso #(
    .WIDTH(BITS_PER_SLOT)
  ) u_piso (
    .clk  (clk),
    .rst  (rst),
    .load (strobe.capture),
    .pdata(pdata_i),
    .sdata(sdata_o)
  );

  assign sync_o   = strobe.frame_end;
  assign load_n_o = ~strobe.capture;
  assign slot_o   = slot_ahead;
endmodule

// File: rtl/tdm_serializer_chk.sv
module tdm_serializer_chk #(
  parameter int BITS_PER_SLOT = 8,
  parameter int NUM_SLOTS     = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic [BITS_PER_SLOT-1:0]      pdata_i,
  input logic                          sdata_o,
  input logic                          sync_o,
  input logic [$clog2(NUM_SLOTS)-1:0]  slot_o,
  input logic                          load_n_o
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  AST_SYNC_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) sync_o |=> !sync_o); // R2
  AST_SYNC_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst) sync_o |-> !load_n_o); // R2
  AST_SYNC_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst) sync_o |-> (slot_o == '0)); // R4
  AST_CAPTURE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !load_n_o |=> load_n_o); // R3
  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst) !load_n_o |=> (slot_o == SLOT_W'($past(slot_o) + 1'b1))); // R4
  AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (rst) load_n_o |=> $stable(slot_o)); // R4
  AST_FIRST_BIT_LSB: assert property (@(posedge clk) disable iff (rst) !load_n_o |=> (sdata_o == $past(pdata_i[0]))); // R6
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (load_n_o && !sync_o && !sdata_o && slot_o == SLOT_W'(1))); // R8
endmodule

bind tdm_serializer tdm_serializer_chk #(
  .BITS_PER_SLOT(BITS_PER_SLOT),
  .NUM_SLOTS    (NUM_SLOTS)
) u_chk (.*);

// File: tb/tdm_serializer_bench.sv
module tdm_serializer_bench;
  localparam int NS = 32;
  localparam int BS = 8;
  localparam int FR = NS * BS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pdata = 8'h00;
  logic       sdata, sync, load_n;
  logic [4:0] slot;

  int checks = 0;
  int errors = 0;
  int pos = 0;
  int frame = 0;
  logic [7:0] sent [NS];

  always #4 clk = ~clk;

  tdm_serializer u_tdm_serializer (
    .clk(clk), .rst(rst), .pdata_i(pdata),
    .sdata_o(sdata), .sync_o(sync), .slot_o(slot), .load_n_o(load_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%0h expected=%0h", req, pos, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int f, input int s);
    return 8'((s * 37 + f * 91 + 5) & 255);
  endfunction

  task automatic clear_sent();
    for (int i = 0; i < NS; i++) sent[i] = 8'h00;
  endtask

  task automatic check_reset_state(input string tag);
    chk(sync == 1'b0, tag, int'(sync), 0);
    chk(load_n == 1'b1, tag, int'(load_n), 1);
    chk(slot == 5'd1, tag, int'(slot), 1);
    chk(sdata == 1'b0, tag, int'(sdata), 0);
  endtask

  // One call per clock; caller is at a falling edge.
  task automatic run_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      int s, b, nxt;
      logic [7:0] v;
      s   = pos / BS;
      b   = pos % BS;
      nxt = (s + 1) % NS;
      chk(sync == (pos == FR - 1), "R1 R2 sync", int'(sync), int'(pos == FR - 1));
      chk(load_n == (b != BS - 1), "R3 load_n", int'(load_n), int'(b != BS - 1));
      chk(slot == 5'(nxt), "R4 slot", int'(slot), nxt);
      chk(sdata == sent[s][b], "R5 R6 sdata", int'(sdata), int'(sent[s][b]));
      if (b == BS - 1) begin
        v = pat((s == NS - 1) ? frame + 1 : frame, nxt);
        pdata = v;
      end else begin
        v = 8'h00;
        pdata = 8'((pos * 13) & 255) ^ 8'hA5; // R7: junk outside capture
      end
      @(negedge clk);
      if (b == BS - 1) sent[nxt] = v;
      pos++;
      if (pos == FR) begin
        pos = 0;
        frame++;
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_sent();
    repeat (3) @(negedge clk);
    check_reset_state("R8 held");
    rst = 1'b0;
    check_reset_state("R8 released");
    run_cycles(3 * FR);
    run_cycles(100);
    rst = 1'b1;
    pdata = 8'hFF;
    @(negedge clk);
    check_reset_state("R8 mid-frame");
    @(negedge clk);
    rst = 1'b0;
    pos = 0;
    frame = 0;
    clear_sent();
    run_cycles(2 * FR + 20);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule